// File: doc/BRIEF.md
# Root Port Link Bring-Up Sequencer

This block is a hardware state machine that takes a root-port controller from power-down to a trained link that is ready for configuration traffic. A single start pulse launches the sequence: the controller is put in root-complex mode, its power-down is lifted, then its soft reset is lifted. After a settle time the PHY is asked to initialise while link training is held off. The address windows are then programmed. When the downstream fundamental reset pin is in use it is pulsed for a minimum time. Only then is link training enabled, and the block waits for link-up.

With the reset pin in use, a long quiet period follows link-up before ready is raised, so that configuration requests are not issued too early. A PHY that never reports done, or a link that never comes up, ends the sequence in an error state with a code. Abort, or the asynchronous reset, returns every output to its safe value: power-down and soft reset asserted, training off, reset pin released.

Every delay and timeout is a parameter counted in clock cycles. The defaults are derived from a clock-frequency parameter in MHz, so a testbench can shorten them.

Top module: `link_bringup_seq`

## Requirements
- R1: After rst_ni goes low, and in the idle state, the outputs are rc_mode_o=0, pwr_down_o=1, soft_rst_o=1, phy_init_o=0, prog_req_o=0, perst_n_o=1, link_train_en_o=0, ready_o=0, err_o=0 and err_code_o=2'b00. This holds at once even when reset is asserted in the middle of a sequence.
- R2: A start_i sampled high in idle sets rc_mode_o at that edge. pwr_down_o falls one cycle later, and soft_rst_o falls one cycle after that.
- R3: phy_init_o rises exactly SETTLE_CYC+1 cycles after soft_rst_o falls, and link_train_en_o stays 0 while phy_init_o rises.
- R4: The edge that samples phy_done_i high raises prog_req_o. prog_req_o stays high until the edge that samples prog_done_i high, and link_train_en_o stays 0 while prog_req_o is high.
- R5: With perst_used_i=1 at start, perst_n_o falls at the edge that samples prog_done_i and stays low for exactly PERST_CYC cycles. It then rises in the same cycle that link_train_en_o rises.
- R6: With perst_used_i=0 at start, perst_n_o never falls, and link_train_en_o rises at the edge that samples prog_done_i.
- R7: With the reset pin in use, ready_o rises QUIET_CYC cycles after the edge that samples link_up_i high. Without it, ready_o rises at that edge. ready_o implies link_train_en_o=1.
- R8: If phy_done_i is not seen within PHY_TMO_CYC cycles of phy_init_o rising, the block enters error with err_o=1, err_code_o=2'b01 and all other outputs at their R1 values.
- R9: If link_up_i is not seen within LINK_TMO_CYC cycles of link_train_en_o rising, the block enters error with err_o=1, err_code_o=2'b10 and all other outputs at their R1 values.
- R10: abort_i sampled high returns every output to its R1 value at that edge, from any state including error, and it takes priority over start_i.
- R11: A start_i pulse in the error state clears err_o and restarts the full sequence as in R2.
- R12: start_i has no effect while a sequence is running or after ready_o is high: output timing and values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted in idle or error |
| abort_i | input | 1 | Return to idle with safe outputs |
| perst_used_i | input | 1 | Use the fundamental reset pin, captured at start |
| phy_done_i | input | 1 | PHY initialisation complete |
| prog_done_i | input | 1 | Address window programming complete |
| link_up_i | input | 1 | Link-up status from the controller |
| rc_mode_o | output | 1 | Root-complex mode select |
| pwr_down_o | output | 1 | Controller power-down, 1 = held down |
| soft_rst_o | output | 1 | Controller soft reset, 1 = held in reset |
| phy_init_o | output | 1 | PHY initialisation request |
| prog_req_o | output | 1 | Address window programming request |
| perst_n_o | output | 1 | Fundamental reset pin, active low |
| link_train_en_o | output | 1 | Link training enable |
| ready_o | output | 1 | Configuration traffic allowed |
| err_o | output | 1 | Sequence stopped on a timeout |
| err_code_o | output | 2 | 01 PHY timeout, 10 link timeout, 00 none |

## Verification
The full sequence is run with the reset pin in use and without it, and with different response delays from the PHY, the programming agent and the link. Each output change is compared with an expected value and cycle gap, which separates fixed-length windows (settle, pin pulse, quiet period) from response-driven steps and exposes off-by-one counts. A PHY that never responds and a link that never comes up tell the two error codes apart. Abort during settle, abort from error, restart from error, asynchronous reset during programming, and stray start pulses while running and after ready show whether the safe state and the no-effect cases hold.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MODE,
    ST_PWR,
    ST_RST,
    ST_SETTLE,
    ST_PHY,
    ST_PROG,
    ST_PERST,
    ST_TRAIN,
    ST_QUIET,
    ST_READY,
    ST_ERR_PHY,
    ST_ERR_LINK
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_PHY  = 2'b01,
    ERR_LINK = 2'b10
  } err_code_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lbs_timer.sv
module lbs_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lbs_fsm.sv
module lbs_fsm
  import lbs_pkg::*;
#(
  parameter int W            = 8,
  parameter int SETTLE_CYC   = 4,
  parameter int PERST_CYC    = 4,
  parameter int QUIET_CYC    = 4,
  parameter int PHY_TMO_CYC  = 4,
  parameter int LINK_TMO_CYC = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic         perst_used_i,
  input  logic         phy_done_i,
  input  logic         prog_done_i,
  input  logic         link_up_i,
  input  logic         tmr_zero_i,
  output seq_state_e   state_o,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o
);

  // timed states last N cycles: load N-1, leave when the count is zero
  localparam logic [W-1:0] LD_SETTLE = W'(SETTLE_CYC - 1);
  localparam logic [W-1:0] LD_PERST  = W'(PERST_CYC - 1);
  localparam logic [W-1:0] LD_QUIET  = W'(QUIET_CYC - 1);
  localparam logic [W-1:0] LD_PHY    = W'(PHY_TMO_CYC - 1);
  localparam logic [W-1:0] LD_LINK   = W'(LINK_TMO_CYC - 1);

  seq_state_e st_q, st_d;
  logic       perst_q, perst_d;

  always_comb begin
    st_d       = st_q;
    perst_d    = perst_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (st_q)
      ST_IDLE, ST_ERR_PHY, ST_ERR_LINK: begin
        if (start_i) begin
          st_d    = ST_MODE;
          perst_d = perst_used_i;
        end
      end
      ST_MODE: st_d = ST_PWR;
      ST_PWR:  st_d = ST_RST;
      ST_RST: begin
        st_d       = ST_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = LD_SETTLE;
      end
      ST_SETTLE: begin
        if (tmr_zero_i) begin
          st_d       = ST_PHY;
          tmr_load_o = 1'b1;
          tmr_val_o  = LD_PHY;
        end
      end
      ST_PHY: begin
        if (phy_done_i)      st_d = ST_PROG;
        else if (tmr_zero_i) st_d = ST_ERR_PHY;
      end
      ST_PROG: begin
        if (prog_done_i) begin
          tmr_load_o = 1'b1;
          if (perst_q) begin
            st_d      = ST_PERST;
            tmr_val_o = LD_PERST;
          end else begin
            st_d      = ST_TRAIN;
            tmr_val_o = LD_LINK;
          end
        end
      end
      ST_PERST: begin
        if (tmr_zero_i) begin
          st_d       = ST_TRAIN;
          tmr_load_o = 1'b1;
          tmr_val_o  = LD_LINK;
        end
      end
      ST_TRAIN: begin
        if (link_up_i) begin
          if (perst_q) begin
            st_d       = ST_QUIET;
            tmr_load_o = 1'b1;
            tmr_val_o  = LD_QUIET;
          end else begin
            st_d = ST_READY;
          end
        end else if (tmr_zero_i) begin
          st_d = ST_ERR_LINK;
        end
      end
      ST_QUIET: if (tmr_zero_i) st_d = ST_READY;
      ST_READY: st_d = ST_READY;
      default:  st_d = ST_IDLE;
    endcase
    if (abort_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      perst_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      perst_q <= perst_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/lbs_drive.sv
module lbs_drive
  import lbs_pkg::*;
(
  input  seq_state_e  state_i,
  output logic        rc_mode_o,
  output logic        pwr_down_o,
  output logic        soft_rst_o,
  output logic        phy_init_o,
  output logic        prog_req_o,
  output logic        perst_n_o,
  output logic        link_train_en_o,
  output logic        ready_o,
  output logic        err_o,
  output err_code_e   err_code_o
);

  always_comb begin
    rc_mode_o       = 1'b0;
    pwr_down_o      = 1'b1;
    soft_rst_o      = 1'b1;
    phy_init_o      = 1'b0;
    prog_req_o      = 1'b0;
    perst_n_o       = 1'b1;
    link_train_en_o = 1'b0;
    ready_o         = 1'b0;
    err_o           = 1'b0;
    err_code_o      = ERR_NONE;
    case (state_i)
      ST_MODE: rc_mode_o = 1'b1;
      ST_PWR: begin
        rc_mode_o  = 1'b1;
        pwr_down_o = 1'b0;
      end
      ST_RST, ST_SETTLE: begin
        rc_mode_o  = 1'b1;
        pwr_down_o = 1'b0;
        soft_rst_o = 1'b0;
      end
      ST_PHY, ST_PROG, ST_PERST, ST_TRAIN, ST_QUIET, ST_READY: begin
        rc_mode_o       = 1'b1;
        pwr_down_o      = 1'b0;
        soft_rst_o      = 1'b0;
        phy_init_o      = 1'b1;
        prog_req_o      = (state_i == ST_PROG);
        perst_n_o       = (state_i != ST_PERST);
        link_train_en_o = (state_i == ST_TRAIN) || (state_i == ST_QUIET) ||
                          (state_i == ST_READY);
        ready_o         = (state_i == ST_READY);
      end
      ST_ERR_PHY: begin
        err_o      = 1'b1;
        err_code_o = ERR_PHY;
      end
      ST_ERR_LINK: begin
        err_o      = 1'b1;
        err_code_o = ERR_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int CLK_MHZ      = 250,
  parameter int SETTLE_CYC   = CLK_MHZ * 1000,    // 1 ms
  parameter int PERST_CYC    = CLK_MHZ * 100,     // 100 us
  parameter int QUIET_CYC    = CLK_MHZ * 100000,  // 100 ms
  parameter int PHY_TMO_CYC  = CLK_MHZ * 10000,   // 10 ms
  parameter int LINK_TMO_CYC = CLK_MHZ * 100000   // 100 ms
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       perst_used_i,
  input  logic       phy_done_i,
  input  logic       prog_done_i,
  input  logic       link_up_i,
  output logic       rc_mode_o,
  output logic       pwr_down_o,
  output logic       soft_rst_o,
  output logic       phy_init_o,
  output logic       prog_req_o,
  output logic       perst_n_o,
  output logic       link_train_en_o,
  output logic       ready_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);

  localparam int MAX_CYC = max2(max2(max2(SETTLE_CYC, PERST_CYC), max2(QUIET_CYC, PHY_TMO_CYC)),
                                LINK_TMO_CYC);
  localparam int TW      = $clog2(MAX_CYC + 1);

  seq_state_e    state;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  err_code_e     code;

  lbs_fsm #(
    .W            (TW),
    .SETTLE_CYC   (SETTLE_CYC),
    .PERST_CYC    (PERST_CYC),
    .QUIET_CYC    (QUIET_CYC),
    .PHY_TMO_CYC  (PHY_TMO_CYC),
    .LINK_TMO_CYC (LINK_TMO_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .abort_i      (abort_i),
    .perst_used_i (perst_used_i),
    .phy_done_i   (phy_done_i),
    .prog_done_i  (prog_done_i),
    .link_up_i    (link_up_i),
    .tmr_zero_i   (tmr_zero),
    .state_o      (state),
    .tmr_load_o   (tmr_load),
    .tmr_val_o    (tmr_val)
  );

  lbs_timer #(.W(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  lbs_drive u_drv (
    .state_i         (state),
    .rc_mode_o       (rc_mode_o),
    .pwr_down_o      (pwr_down_o),
    .soft_rst_o      (soft_rst_o),
    .phy_init_o      (phy_init_o),
    .prog_req_o      (prog_req_o),
    .perst_n_o       (perst_n_o),
    .link_train_en_o (link_train_en_o),
    .ready_o         (ready_o),
    .err_o           (err_o),
    .err_code_o      (code)
  );

  assign err_code_o = code;

endmodule

// File: rtl/lbs_chk.sv
module lbs_chk #(
  parameter int PERST_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic abort_i,
  input logic rc_mode_o,
  input logic pwr_down_o,
  input logic soft_rst_o,
  input logic phy_init_o,
  input logic prog_req_o,
  input logic perst_n_o,
  input logic link_train_en_o,
  input logic ready_o,
  input logic err_o
);

  logic [31:0] lo_cnt;
  logic        fresh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      fresh  <= 1'b1;
    end else begin
      lo_cnt <= perst_n_o ? '0 : lo_cnt + 1'b1;
      fresh  <= 1'b0;
    end
  end

  assert_err_safe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (pwr_down_o && soft_rst_o && !link_train_en_o && perst_n_o && !rc_mode_o));

  assert_pwr_after_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_down_o) |-> $past(rc_mode_o));

  assert_rst_after_pwr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(soft_rst_o) |-> !$past(pwr_down_o));

  assert_phy_no_train_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phy_init_o) |-> !link_train_en_o);

  assert_prog_no_train_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> (phy_init_o && !link_train_en_o));

  assert_train_pin_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_train_en_o) |-> perst_n_o);

  assert_pin_pulse_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(perst_n_o) && !$past(abort_i) && !fresh) |-> (lo_cnt == 32'(PERST_CYC)));

  assert_ready_trained_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (link_train_en_o && perst_n_o && !pwr_down_o));

  assert_abort_safe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (pwr_down_o && soft_rst_o && !ready_o && !err_o && perst_n_o));

endmodule

bind link_bringup_seq lbs_chk #(.PERST_CYC(PERST_CYC)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .abort_i         (abort_i),
  .rc_mode_o       (rc_mode_o),
  .pwr_down_o      (pwr_down_o),
  .soft_rst_o      (soft_rst_o),
  .phy_init_o      (phy_init_o),
  .prog_req_o      (prog_req_o),
  .perst_n_o       (perst_n_o),
  .link_train_en_o (link_train_en_o),
  .ready_o         (ready_o),
  .err_o           (err_o)
);

// File: tb/sim_link_bringup_seq.sv
`timescale 1ns/1ps
module sim_link_bringup_seq;

  localparam int S  = 12;
  localparam int P  = 5;
  localparam int Q  = 20;
  localparam int PT = 30;
  localparam int LT = 40;

  // {rc, pd, sr, pi, pr, pn, lt, rdy, err, code[1:0]}
  localparam logic [10:0] IDLE_V  = 11'b01100100000;
  localparam logic [10:0] MODE_V  = 11'b11100100000;
  localparam logic [10:0] PWR_V   = 11'b10100100000;
  localparam logic [10:0] RST_V   = 11'b10000100000;
  localparam logic [10:0] PHY_V   = 11'b10010100000;
  localparam logic [10:0] PROG_V  = 11'b10011100000;
  localparam logic [10:0] PERST_V = 11'b10010000000;
  localparam logic [10:0] TRAIN_V = 11'b10010110000;
  localparam logic [10:0] READY_V = 11'b10010111000;
  localparam logic [10:0] ERRP_V  = 11'b01100100101;
  localparam logic [10:0] ERRL_V  = 11'b01100100110;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, abort_i = 1'b0, perst_used_i = 1'b0;
  logic phy_done_i = 1'b0, prog_done_i = 1'b0, link_up_i = 1'b0;
  logic rc_mode_o, pwr_down_o, soft_rst_o, phy_init_o, prog_req_o, perst_n_o;
  logic link_train_en_o, ready_o, err_o;
  logic [1:0] err_code_o;

  always #2 clk_i = ~clk_i;

  link_bringup_seq #(
    .SETTLE_CYC(S), .PERST_CYC(P), .QUIET_CYC(Q), .PHY_TMO_CYC(PT), .LINK_TMO_CYC(LT)
  ) u0 (.*);

  wire [10:0] obs = {rc_mode_o, pwr_down_o, soft_rst_o, phy_init_o, prog_req_o, perst_n_o,
                     link_train_en_o, ready_o, err_o, err_code_o};

  int checks = 0, errors = 0;
  logic [10:0] exp_vec[$];
  int          exp_gap[$];
  string       exp_tag[$];
  logic [10:0] prev;
  int          gap_cnt = 0;
  bit          mon_on = 0;
  int d_phy = 0, d_prog = 0, d_link = 0, c_phy = 0, c_prog = 0, c_link = 0;

  task automatic expect_item(input logic [10:0] v, input int g, input string tag);
    exp_vec.push_back(v);
    exp_gap.push_back(g);
    exp_tag.push_back(tag);
  endtask

  // scoreboard monitor: each output change pops one expected item; gap 0 = timing not checked
  always @(negedge clk_i) begin
    if (mon_on) begin
      logic [10:0] ev;
      int eg;
      string et;
      gap_cnt++;
      if (obs !== prev) begin
        if (exp_vec.size() == 0) begin
          checks++; errors++;
          $display("FAIL unexpected change: got %b expected %b", obs, prev);
        end else begin
          ev = exp_vec.pop_front(); eg = exp_gap.pop_front(); et = exp_tag.pop_front();
          checks++;
          if (obs !== ev) begin
            errors++;
            $display("FAIL %s value: got %b expected %b", et, obs, ev);
          end
          if (eg != 0) begin
            checks++;
            if (gap_cnt != eg) begin
              errors++;
              $display("FAIL %s gap: got %0d expected %0d", et, gap_cnt, eg);
            end
          end
        end
        prev    = obs;
        gap_cnt = 0;
      end
    end
  end

  // responders: raise done/up d cycles after the request is seen; d<0 never
  always @(negedge clk_i) begin
    if (pwr_down_o) begin
      phy_done_i = 0; prog_done_i = 0; link_up_i = 0;
      c_phy = 0; c_prog = 0; c_link = 0;
    end else begin
      if (phy_init_o && !phy_done_i && d_phy >= 0) begin
        if (c_phy == d_phy) phy_done_i = 1; else c_phy++;
      end
      if (prog_req_o && !prog_done_i && d_prog >= 0) begin
        if (c_prog == d_prog) prog_done_i = 1; else c_prog++;
      end
      if (link_train_en_o && !link_up_i && d_link >= 0) begin
        if (c_link == d_link) link_up_i = 1; else c_link++;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
  endtask

  task automatic pulse_abort();
    @(negedge clk_i); abort_i = 1;
    @(negedge clk_i); abort_i = 0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_vec.size() != 0 && n < 3000) begin
      @(negedge clk_i); n++;
    end
    if (exp_vec.size() != 0) begin
      checks++; errors++;
      $display("FAIL %s drain: got %0d pending expected 0", tag, exp_vec.size());
      exp_vec.delete(); exp_gap.delete(); exp_tag.delete();
    end
  endtask

  task automatic check_now(input logic [10:0] v, input string tag);
    checks++;
    if (obs !== v) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, obs, v);
    end
  endtask

  task automatic front(input string tag);
    expect_item(MODE_V, 0, tag);
    expect_item(PWR_V, 1, "R2");
    expect_item(RST_V, 1, "R2");
    expect_item(PHY_V, S + 1, "R3");
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_now(IDLE_V, "R1 in reset");
    rst_ni = 1;
    @(negedge clk_i);
    check_now(IDLE_V, "R1 after reset");
    prev = obs; mon_on = 1;

    // A: pin in use, delayed responses (R2 R3 R4 R5 R7)
    perst_used_i = 1; d_phy = 2; d_prog = 0; d_link = 3;
    front("R2");
    expect_item(PROG_V, 3, "R4");
    expect_item(PERST_V, 1, "R5");
    expect_item(TRAIN_V, P, "R5");
    expect_item(READY_V, 3 + 1 + Q, "R7");
    pulse_start(); drain("A");
    expect_item(IDLE_V, 0, "R10");
    pulse_abort(); drain("A abort");

    // B: pin not used (R6 R7)
    perst_used_i = 0; d_phy = 0; d_prog = 4; d_link = 0;
    front("R2");
    expect_item(PROG_V, 1, "R4");
    expect_item(TRAIN_V, 5, "R6");
    expect_item(READY_V, 1, "R7");
    pulse_start(); drain("B");
    expect_item(IDLE_V, 0, "R10");
    pulse_abort(); drain("B abort");

    // C: PHY timeout (R8), then restart from error (R11)
    perst_used_i = 1; d_phy = -1;
    front("R2");
    expect_item(ERRP_V, PT, "R8");
    pulse_start(); drain("R8");
    perst_used_i = 0; d_phy = 1; d_prog = 1; d_link = 0;
    front("R11");
    expect_item(PROG_V, 2, "R11");
    expect_item(TRAIN_V, 2, "R11");
    expect_item(READY_V, 1, "R11");
    pulse_start(); drain("R11");
    expect_item(IDLE_V, 0, "R10");
    pulse_abort(); drain("C abort");

    // D: link timeout (R9), abort from error (R10)
    perst_used_i = 0; d_phy = 0; d_prog = 0; d_link = -1;
    front("R2");
    expect_item(PROG_V, 1, "R4");
    expect_item(TRAIN_V, 1, "R6");
    expect_item(ERRL_V, LT, "R9");
    pulse_start(); drain("R9");
    expect_item(IDLE_V, 0, "R10 from error");
    pulse_abort(); drain("R10");

    // E: abort during settle (R10)
    perst_used_i = 1; d_phy = 0; d_link = 0;
    expect_item(MODE_V, 0, "R2");
    expect_item(PWR_V, 1, "R2");
    expect_item(RST_V, 1, "R2");
    pulse_start(); drain("E");
    repeat (3) @(negedge clk_i);
    expect_item(IDLE_V, 0, "R10 settle");
    pulse_abort(); drain("R10");
    repeat (S + 5) @(negedge clk_i);
    check_now(IDLE_V, "R10 stays idle");

    // F: stray start pulses ignored (R12)
    perst_used_i = 0; d_phy = 0; d_prog = 0; d_link = 0;
    front("R2");
    expect_item(PROG_V, 1, "R12");
    expect_item(TRAIN_V, 1, "R12");
    expect_item(READY_V, 1, "R12");
    pulse_start();
    while (obs !== RST_V) @(negedge clk_i);
    pulse_start();
    drain("R12");
    pulse_start();
    repeat (5) @(negedge clk_i);
    check_now(READY_V, "R12 after ready");
    expect_item(IDLE_V, 0, "R10");
    pulse_abort(); drain("F abort");

    // G: async reset while programming (R1)
    perst_used_i = 1; d_phy = 0; d_prog = -1;
    front("R2");
    expect_item(PROG_V, 1, "R4");
    pulse_start(); drain("G");
    expect_item(IDLE_V, 0, "R1 async");
    @(negedge clk_i); #1 rst_ni = 0;
    drain("R1");
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    check_now(IDLE_V, "R1 after mid reset");

    finish_up();
  end

endmodule